// File: doc/BRIEF.md
# Three-Level Sign-Magnitude Pin Modulator

This block turns one audio channel's two's-complement samples into a three-state pin: driven high, driven low, or released to high impedance. An external resistor on the pin converts the three states into a small current source, sink or nothing. Several channels are summed off chip by joining their resistors at one node.

The sample is split into a sign and a magnitude. A first-order accumulator modulator one bit narrower than the sample runs on the magnitude alone. Its carry decides whether the pin is driven during the next period. The sign decides which way the pin is driven. Compared with a two-level bitstream, the narrower accumulator carries each DC idle pattern one octave higher. A step strobe sets the modulator rate. Between strobes the pin keeps its last state.

A small state machine holds the pin phase in three named states. `PH_RELEASE` means high impedance. `PH_SOURCE` means driven high. `PH_SINK` means driven low. On a strobe cycle it makes one of these transitions:
- to `PH_SOURCE` when the carry fires and the sample is non-negative;
- to `PH_SINK` when the carry fires and the sample is negative;
- to `PH_RELEASE` when there is no carry.

On any other cycle it holds its state. Enable and data are both decoded from this single state register.

Top module: `tri_level_pin_dac`

## Requirements
- R1: While `rst_n` is low, `drv_en` and `drv_val` are 0 and the accumulator is cleared. After reset is released, the first strobes behave as though the accumulator starts from 0.
- R2: The modulator magnitude is the absolute value of the sample, and -128 saturates to 127. With the sample held constant, any 128 consecutive strobes give exactly `magnitude` strobes after which `drv_en` is 1.
- R3: Bit 7 of `sample` is the sign. For a non-negative sample, a strobe whose carry fires leaves `drv_en`=1 and `drv_val`=1 after the edge.
- R4: For a negative sample, a strobe whose carry fires leaves `drv_en`=1 and `drv_val`=0 after the edge.
- R5: A strobe without a carry leaves `drv_en`=0 (pin released). Whenever `drv_en` is 0, `drv_val` is also 0.
- R6: A zero sample never produces a carry, so the pin stays released for as long as the sample is zero.
- R7: When `step` is low at an edge, `drv_en`, `drv_val` and the accumulator keep their values, whatever `sample` does.
- R8: On a strobe edge the accumulator adds the magnitude modulo 128, and the carry is bit 7 of the 8-bit sum. `drv_en` and `drv_val` change together on that same edge, one register after the inputs.
- R9: When `drv_en` is 1, `pad` carries `drv_val`. Otherwise `pad` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Modulator strobe; one accumulator step per high cycle |
| sample | input | 8 | Two's-complement audio sample |
| drv_en | output | 1 | Registered pin output enable |
| drv_val | output | 1 | Registered pin drive level |
| pad | output | 1 | Three-state pin: `drv_val` when enabled, else high impedance |

## Verification
Within one strobe cycle, the sign and the carry can change at the same time. The carry comes from the magnitude of a new sample, while the new sign picks the direction of that same pulse. A stale polarity or a lagging magnitude would show up only here. To provoke this case, the bench flips large magnitudes between positive and negative on every strobe, interleaves random strobe gaps, and compares enable, data and pin on every cycle against a reference accumulator kept in the bench. A second overlap is a sample change that lands on a cycle without a strobe. The bench judges it by checking that the outputs hold and that the following carry sequence continues from the undisturbed accumulator.

// File: rtl/tlpd_pkg.sv
package tlpd_pkg;

    // Pin phase; encoding is {enable, level} so outputs come straight off the register.
    typedef enum logic [1:0] {
        PH_RELEASE = 2'b00,
        PH_SINK    = 2'b10,
        PH_SOURCE  = 2'b11
    } pin_phase_e;

endpackage

// File: rtl/tlpd_sign_mag.sv
module tlpd_sign_mag #(
    parameter int SAMPLE_W = 8,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                neg,
    output logic [MAG_W-1:0]    mag
);

    logic [SAMPLE_W-1:0] negated;

    always_comb begin
        neg     = sample[SAMPLE_W-1];
        negated = '0 - sample;
        if (!neg) begin
            mag = sample[MAG_W-1:0];
        end else if (negated[SAMPLE_W-1]) begin
            // most negative code: no positive twin, clamp to full scale
            mag = '1;
        end else begin
            mag = negated[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/tlpd_fo_mod.sv
module tlpd_fo_mod #(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [MAG_W-1:0] mag,
    output logic             fire
);

    logic [MAG_W-1:0] acc_q;
    logic [MAG_W:0]   sum;

    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, mag};
        fire = sum[MAG_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/tlpd_phase_fsm.sv
module tlpd_phase_fsm
    import tlpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic fire,
    input  logic neg,
    output logic drv_en,
    output logic drv_val
);

    pin_phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RELEASE, PH_SOURCE, PH_SINK: begin
                if (step) begin
                    if (!fire)    state_d = PH_RELEASE;
                    else if (neg) state_d = PH_SINK;
                    else          state_d = PH_SOURCE;
                end
            end
            default: state_d = PH_RELEASE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_RELEASE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_SOURCE: begin drv_en = 1'b1; drv_val = 1'b1; end
            PH_SINK:   begin drv_en = 1'b1; drv_val = 1'b0; end
            default:   begin drv_en = 1'b0; drv_val = 1'b0; end
        endcase
    end

endmodule

// File: rtl/tri_level_pin_dac.sv
module tri_level_pin_dac #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                drv_en,
    output logic                drv_val,
    output wire                 pad
);

    localparam int MAG_W = SAMPLE_W - 1;

    logic             neg;
    logic [MAG_W-1:0] mag;
    logic             fire;

    tlpd_sign_mag #(.SAMPLE_W(SAMPLE_W)) u_split (
        .sample (sample),
        .neg    (neg),
        .mag    (mag)
    );

    tlpd_fo_mod #(.MAG_W(MAG_W)) u_mod (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .mag   (mag),
        .fire  (fire)
    );

    tlpd_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .fire    (fire),
        .neg     (neg),
        .drv_en  (drv_en),
        .drv_val (drv_val)
    );

    assign pad = drv_en ? drv_val : 1'bz;

endmodule

// File: rtl/tlpd_checker.sv
module tlpd_checker #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step,
    input logic [SAMPLE_W-1:0] sample,
    input logic                drv_en,
    input logic                drv_val
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!drv_en && !drv_val)); // R1

    AST_SOURCE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sample[SAMPLE_W-1]) |=> (!drv_en || drv_val)); // R3

    AST_SINK_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sample[SAMPLE_W-1]) |=> !drv_val); // R4

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> !drv_val); // R5

    AST_ZERO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && sample == '0) |=> !drv_en); // R6

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(drv_en) && $stable(drv_val))); // R7

endmodule

bind tri_level_pin_dac tlpd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .sample  (sample),
    .drv_en  (drv_en),
    .drv_val (drv_val)
);

// File: tb/tb_tri_level_pin_dac.sv
module tb_tri_level_pin_dac;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       step = 1'b0;
    logic [7:0] sample = 8'h00;
    logic       drv_en, drv_val;
    wire        pad;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_acc = 0;
    bit m_en = 0;
    bit m_val = 0;

    tri_level_pin_dac dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .sample  (sample),
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .pad     (pad)
    );

    always #2.5 clk = ~clk;

    function automatic int mag_of(logic [7:0] s);
        int v;
        v = int'($signed(s));
        if (v < 0) v = -v;
        if (v > 127) v = 127;
        return v;
    endfunction

    task automatic check_bit(logic got, logic exp, string req, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic check_int(int got, int exp, string req, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Drive at a falling edge, model the rising edge, compare at the next falling edge (R8).
    task automatic tick(logic [7:0] s, bit st);
        int sum;
        string req;
        sample = s;
        step   = st;
        @(posedge clk);
        if (st) begin
            sum   = m_acc + mag_of(s);
            m_en  = (sum >= 128);
            m_val = m_en && !s[7];
            m_acc = sum % 128;
        end
        @(negedge clk);
        if (!st)        req = "R7";
        else if (!m_en) req = "R5";
        else if (s[7])  req = "R4";
        else            req = "R3";
        check_bit(drv_en, m_en, req, "drv_en");
        check_bit(drv_val, m_val, req, "drv_val");
        if (m_en) check_bit(pad, m_val, "R9", "pad");
    endtask

    task automatic density(logic [7:0] s, int exp, string req);
        int cnt;
        cnt = 0;
        for (int i = 0; i < 128; i++) begin
            tick(s, 1'b1);
            if (drv_en) cnt++;
        end
        check_int(cnt, exp, req, $sformatf("pulses for sample %0h", s));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_bit(drv_en, 1'b0, "R1", "drv_en in reset");
        check_bit(drv_val, 1'b0, "R1", "drv_val in reset");
        m_acc = 0; m_en = 0; m_val = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        #1 rst_n = 1'b0;
        do_reset();

        // R1 / R8: from a clear accumulator, 64 fires on the second strobe
        tick(8'd64, 1'b1);
        check_bit(drv_en, 1'b0, "R1", "first strobe after reset");
        tick(8'd64, 1'b1);
        check_bit(drv_en, 1'b1, "R8", "carry on second strobe");

        // R2 density and saturation
        density(8'h01, 1, "R2");
        density(8'hFF, 1, "R2");
        density(8'h7F, 127, "R2");
        density(8'h80, 127, "R2");
        density(8'hC0, 64, "R2");
        density(8'h25, 37, "R2");

        // R6: zero stays released
        begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < 200; i++) begin
                tick(8'h00, 1'b1);
                if (drv_en) cnt++;
            end
            check_int(cnt, 0, "R6", "pulses for zero sample");
        end

        // R7: hold with no strobe while the sample moves
        begin
            logic en0, val0;
            for (int i = 0; i < 40; i++) tick(8'h70, 1'b1);
            while (!drv_en) tick(8'h70, 1'b1);
            en0 = drv_en; val0 = drv_val;
            for (int i = 0; i < 30; i++) tick(8'($urandom), 1'b0);
            check_bit(drv_en, en0, "R7", "enable held");
            check_bit(drv_val, val0, "R7", "level held");
            for (int i = 0; i < 50; i++) tick(8'h70, 1'b1);
        end

        // Sign flips on every strobe with large magnitudes (R3/R4 same cycle)
        for (int i = 0; i < 600; i++) begin
            logic [7:0] s;
            s = 8'(64 + ($urandom % 64));
            if (i % 2 == 1) s = 8'(0 - s);
            tick(s, ($urandom % 5) != 0);
        end

        // Constrained random
        for (int i = 0; i < 3000; i++) tick(8'($urandom), ($urandom % 4) != 0);

        // R1: reset mid-run clears the accumulator
        for (int i = 0; i < 5; i++) tick(8'h33, 1'b1);
        do_reset();
        tick(8'd100, 1'b1);
        check_bit(drv_en, 1'b0, "R1", "no carry from cleared accumulator");
        tick(8'd100, 1'b1);
        check_bit(drv_en, 1'b1, "R1", "carry after 200");
        for (int i = 0; i < 500; i++) tick(8'($urandom), ($urandom % 3) != 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule